// File: doc/BRIEF.md
# Privilege-Gated Performance Monitor Register File

This block is the register file of a minimal performance monitor that has no event counters of its own. A processor pipeline hands it a coprocessor-style register access. The access carries a register select made of a primary number, a secondary number and an op2 field, a read/write strobe, 32-bit write data and the current privilege level. In the same cycle the block returns read data, or an undefined flag that the pipeline turns into an undefined-instruction trap.

Each register has its own update rule:
- Two pairs of set/clear views share one backing register each.
- The overflow status register is write-one-to-clear.
- The control register has a partial write mask. Its reset value is the top byte of an implementor ID input.
- Several registers read as zero and ignore writes.

Access rights depend on privilege. Interrupt-enable registers are for privileged code only. The user-enable register is read-only to unprivileged code. Every other register is open to unprivileged code only while user enable is set.

Top module: `pmu_regfile`

## Requirements
- R1: Registers decode only at primary number 9. Secondary 12 selects, by op2: 0 control, 1 count-enable set, 2 count-enable clear, 3 overflow status, 4 software increment, 5 counter select. Secondary 13 selects, by op2: 0 cycle counter, 1 event type, 2 event count. Secondary 14 selects, by op2: 0 user enable, 1 interrupt-enable set, 2 interrupt-enable clear. Any other select raises `undef`.
- R2: After reset the control register reads as impl_id[31:24] in bits 31:24, with bits 23:0 zero.
- R3: A control register write changes only bits 0, 3, 4 and 5 (mask 0x39). All other bits keep their value.
- R4: Count-enable set ORs in bit 31 of the write data, and count-enable clear removes bit 31 if it is written as 1. Other data bits are ignored. Both views read the same shared register, which resets to zero.
- R5: Interrupt-enable set and clear behave the same way on their own shared bit-31 register, which resets to zero.
- R6: A write to overflow status clears every bit written as 1. The register reads zero after reset.
- R7: Event type stores only the low 8 bits of a write and reads back zero above bit 7. It resets to zero.
- R8: User enable stores only bit 0 of a write and resets to zero.
- R9: Cycle counter, event count, counter select and software increment always read zero and ignore writes.
- R10: priv == 0 means unprivileged, and any other value means privileged. Any unprivileged access to the interrupt-enable registers raises `undef`.
- R11: An unprivileged read of user enable completes. An unprivileged write to it raises `undef`.
- R12: Every other register raises `undef` on an unprivileged access while user enable is 0, and completes while it is 1.
- R13: An access that raises `undef` changes no register and returns read data 0. A completed write also returns read data 0.
- R14: When `req_valid` is 0, `undef` and `rd_data` are 0 and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| sel_primary | input | 4 | Primary register number |
| sel_secondary | input | 4 | Secondary register number |
| sel_op2 | input | 3 | Register within the secondary group |
| wr_data | input | 32 | Write data |
| priv | input | 2 | Privilege level, 0 = unprivileged |
| impl_id | input | 32 | Implementor ID; top byte seeds the control register at reset |
| rd_data | output | 32 | Read data, valid in the request cycle |
| undef | output | 1 | Access denied or undecoded |

## Verification
A corrupted bit in any stored register shows up on `rd_data` at the first granted read of that register. Because responses are combinational, that read comes in the same cycle the read is issued. A wrong user-enable bit shows up at once as a wrong `undef` on the next unprivileged access to a gated register. A write that leaked through a denied access is exposed by a privileged read-back issued right after the denied one.

// File: rtl/pmu_regs_pkg.sv
package pmu_regs_pkg;

    localparam int WORD_W  = 32;
    localparam int EVT_W   = 8;
    localparam int SHARED_BIT = WORD_W - 1;

    typedef enum logic [3:0] {
        RG_CTRL,
        RG_CNTEN_SET,
        RG_CNTEN_CLR,
        RG_OVF,
        RG_SWINC,
        RG_CSEL,
        RG_CCNT,
        RG_EVTYPE,
        RG_EVCNT,
        RG_UEN,
        RG_IEN_SET,
        RG_IEN_CLR,
        RG_NONE
    } pmu_reg_e;

    typedef enum logic [1:0] {
        ACC_GATED,
        ACC_PRIV_ONLY,
        ACC_USER_RO,
        ACC_NONE
    } acc_class_e;

    typedef struct packed {
        logic       hit;
        pmu_reg_e   id;
        acc_class_e cls;
    } sel_info_t;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic              cnten;
        logic              ien;
        logic [WORD_W-1:0] ovf;
        logic [EVT_W-1:0]  evtype;
        logic              uen;
    } pmu_state_t;

    function automatic logic shared_bit_next(input logic cur,
                                             input logic data_bit,
                                             input logic is_set);
        return is_set ? (cur | data_bit) : (cur & ~data_bit);
    endfunction

endpackage

// File: rtl/pmu_sel_decode.sv
module pmu_sel_decode
    import pmu_regs_pkg::*;
#(
    parameter int PRI_W     = 4,
    parameter int SEC_W     = 4,
    parameter int OP2_W     = 3,
    parameter int PRIMARY   = 9,
    parameter int SEC_CTRL  = 12,
    parameter int SEC_CNT   = 13,
    parameter int SEC_IRQ   = 14
) (
    input  logic [PRI_W-1:0] primary,
    input  logic [SEC_W-1:0] secondary,
    input  logic [OP2_W-1:0] op2,
    output sel_info_t        info
);
    pmu_reg_e id;

    always_comb begin
        id = RG_NONE;
        if (int'(primary) == PRIMARY) begin
            if (int'(secondary) == SEC_CTRL) begin
                case (op2)
                    3'd0: id = RG_CTRL;
                    3'd1: id = RG_CNTEN_SET;
                    3'd2: id = RG_CNTEN_CLR;
                    3'd3: id = RG_OVF;
                    3'd4: id = RG_SWINC;
                    3'd5: id = RG_CSEL;
                    default: id = RG_NONE;
                endcase
            end else if (int'(secondary) == SEC_CNT) begin
                case (op2)
                    3'd0: id = RG_CCNT;
                    3'd1: id = RG_EVTYPE;
                    3'd2: id = RG_EVCNT;
                    default: id = RG_NONE;
                endcase
            end else if (int'(secondary) == SEC_IRQ) begin
                case (op2)
                    3'd0: id = RG_UEN;
                    3'd1: id = RG_IEN_SET;
                    3'd2: id = RG_IEN_CLR;
                    default: id = RG_NONE;
                endcase
            end
        end
    end

    always_comb begin
        info.id  = id;
        info.hit = (id != RG_NONE);
        case (id)
            RG_NONE:                info.cls = ACC_NONE;
            RG_IEN_SET, RG_IEN_CLR: info.cls = ACC_PRIV_ONLY;
            RG_UEN:                 info.cls = ACC_USER_RO;
            default:                info.cls = ACC_GATED;
        endcase
    end
endmodule

// File: rtl/pmu_access_gate.sv
module pmu_access_gate
    import pmu_regs_pkg::*;
#(
    parameter int PRIV_W = 2
) (
    input  logic              valid,
    input  logic              write,
    input  sel_info_t         info,
    input  logic [PRIV_W-1:0] priv,
    input  logic              uen,
    output logic              grant,
    output logic              deny
);
    logic unpriv;
    logic user_block;

    assign unpriv = (priv == '0);

    always_comb begin
        user_block = 1'b0;
        case (info.cls)
            ACC_PRIV_ONLY: user_block = 1'b1;
            ACC_USER_RO:   user_block = write;
            ACC_GATED:     user_block = ~uen;
            default:       user_block = 1'b1;
        endcase
    end

    assign deny  = valid & (~info.hit | (unpriv & user_block));
    assign grant = valid & ~deny;
endmodule

// File: rtl/pmu_reg_store.sv
module pmu_reg_store
    import pmu_regs_pkg::*;
#(
    parameter logic [WORD_W-1:0] CTRL_WMASK = 32'h0000_0039,
    parameter int                ID_KEEP    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] impl_id,
    input  logic              wr_en,
    input  pmu_reg_e          id,
    input  logic [WORD_W-1:0] wdata,
    output pmu_state_t        state,
    output logic [WORD_W-1:0] rd_word
);
    localparam logic [WORD_W-1:0] ID_MASK = ~((WORD_W'(1) << (WORD_W - ID_KEEP)) - WORD_W'(1));

    pmu_state_t st;
    assign state = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.ctrl   <= impl_id & ID_MASK;
            st.cnten  <= 1'b0;
            st.ien    <= 1'b0;
            st.ovf    <= '0;
            st.evtype <= '0;
            st.uen    <= 1'b0;
        end else if (wr_en) begin
            case (id)
                RG_CTRL:      st.ctrl   <= (st.ctrl & ~CTRL_WMASK) | (wdata & CTRL_WMASK);
                RG_CNTEN_SET: st.cnten  <= shared_bit_next(st.cnten, wdata[SHARED_BIT], 1'b1);
                RG_CNTEN_CLR: st.cnten  <= shared_bit_next(st.cnten, wdata[SHARED_BIT], 1'b0);
                RG_IEN_SET:   st.ien    <= shared_bit_next(st.ien, wdata[SHARED_BIT], 1'b1);
                RG_IEN_CLR:   st.ien    <= shared_bit_next(st.ien, wdata[SHARED_BIT], 1'b0);
                RG_OVF:       st.ovf    <= st.ovf & ~wdata;
                RG_EVTYPE:    st.evtype <= wdata[EVT_W-1:0];
                RG_UEN:       st.uen    <= wdata[0];
                default:      ;
            endcase
        end
    end

    always_comb begin
        rd_word = '0;
        case (id)
            RG_CTRL:                    rd_word = st.ctrl;
            RG_CNTEN_SET, RG_CNTEN_CLR: rd_word[SHARED_BIT] = st.cnten;
            RG_IEN_SET, RG_IEN_CLR:     rd_word[SHARED_BIT] = st.ien;
            RG_OVF:                     rd_word = st.ovf;
            RG_EVTYPE:                  rd_word[EVT_W-1:0] = st.evtype;
            RG_UEN:                     rd_word[0] = st.uen;
            default:                    rd_word = '0;
        endcase
    end

    // R3: bits outside the write mask never move after reset
    assert_ctrl_fixed_bits_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((st.ctrl & ~CTRL_WMASK) == ($past(st.ctrl) & ~CTRL_WMASK)));

    // R6: nothing ever sets an overflow bit
    assert_ovf_never_sets_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((st.ovf & ~$past(st.ovf)) == '0));
endmodule

// File: rtl/pmu_regfile.sv
module pmu_regfile
    import pmu_regs_pkg::*;
#(
    parameter int                PRI_W      = 4,
    parameter int                SEC_W      = 4,
    parameter int                OP2_W      = 3,
    parameter int                PRIV_W     = 2,
    parameter logic [WORD_W-1:0] CTRL_WMASK = 32'h0000_0039,
    parameter int                ID_KEEP    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [PRI_W-1:0]  sel_primary,
    input  logic [SEC_W-1:0]  sel_secondary,
    input  logic [OP2_W-1:0]  sel_op2,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [PRIV_W-1:0] priv,
    input  logic [WORD_W-1:0] impl_id,
    output logic [WORD_W-1:0] rd_data,
    output logic              undef
);
    sel_info_t         info;
    pmu_state_t        state;
    logic              grant;
    logic              deny;
    logic [WORD_W-1:0] rd_word;

    pmu_sel_decode #(
        .PRI_W(PRI_W), .SEC_W(SEC_W), .OP2_W(OP2_W)
    ) u_decode (
        .primary   (sel_primary),
        .secondary (sel_secondary),
        .op2       (sel_op2),
        .info      (info)
    );

    pmu_access_gate #(.PRIV_W(PRIV_W)) u_gate (
        .valid (req_valid),
        .write (req_write),
        .info  (info),
        .priv  (priv),
        .uen   (state.uen),
        .grant (grant),
        .deny  (deny)
    );

    pmu_reg_store #(.CTRL_WMASK(CTRL_WMASK), .ID_KEEP(ID_KEEP)) u_store (
        .clk     (clk),
        .rst     (rst),
        .impl_id (impl_id),
        .wr_en   (grant & req_write),
        .id      (info.id),
        .wdata   (wr_data),
        .state   (state),
        .rd_word (rd_word)
    );

    assign undef   = deny;
    assign rd_data = (grant && !req_write) ? rd_word : '0;

    // R13: a refused access returns zero data
    assert_undef_zero_data_R13: assert property (@(posedge clk) disable iff (rst)
        undef |-> (rd_data == '0));

    // R13: a refused access leaves all state untouched
    assert_denied_hold_R13: assert property (@(posedge clk) disable iff (rst)
        undef |=> $stable(state));

    // R14: idle cycles are quiet and change nothing
    assert_idle_quiet_R14: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!undef && rd_data == '0));
    assert_idle_hold_R14: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(state));

    // R10: interrupt-enable pair is closed to unprivileged code
    assert_irq_priv_only_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && priv == '0 && (info.id == RG_IEN_SET || info.id == RG_IEN_CLR)) |-> undef);

    // R11: unprivileged writes cannot change user enable
    assert_uen_user_write_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && priv == '0 && info.id == RG_UEN) |=> $stable(state.uen));
endmodule

// File: tb/pmu_regfile_test.sv
module pmu_regfile_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [3:0]  sel_primary;
    logic [3:0]  sel_secondary;
    logic [2:0]  sel_op2;
    logic [31:0] wr_data;
    logic [1:0]  priv;
    logic [31:0] impl_id;
    logic [31:0] rd_data;
    logic        undef;

    int checks = 0;
    int errors = 0;
    logic [31:0] r;
    logic        u;

    localparam logic [31:0] ID_VAL   = 32'hA512_3456;
    localparam logic [31:0] CTRL_RST = 32'hA500_0000;

    always #2 clk = ~clk;

    pmu_regfile uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .sel_primary(sel_primary), .sel_secondary(sel_secondary), .sel_op2(sel_op2),
        .wr_data(wr_data), .priv(priv), .impl_id(impl_id),
        .rd_data(rd_data), .undef(undef)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [3:0] pri, input logic [3:0] sec,
                       input logic [2:0] op2, input logic [31:0] d, input logic [1:0] pl,
                       output logic [31:0] rd, output logic ud);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; sel_primary = pri; sel_secondary = sec;
        sel_op2 = op2; wr_data = d; priv = pl;
        #1;
        rd = rd_data; ud = undef;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; wr_data = '0;
    endtask

    task automatic rd9(input logic [3:0] sec, input logic [2:0] op2, input logic [1:0] pl,
                       output logic [31:0] rd, output logic ud);
        acc(1'b0, 4'd9, sec, op2, 32'h0, pl, rd, ud);
    endtask

    task automatic wr9(input logic [3:0] sec, input logic [2:0] op2, input logic [31:0] d,
                       input logic [1:0] pl, output logic ud);
        logic [31:0] dummy;
        acc(1'b1, 4'd9, sec, op2, d, pl, dummy, ud);
        check("R13 write returns zero data", dummy, 32'h0);
    endtask

    task automatic t_reset;
        rd9(12, 0, 1, r, u); check("R2 ctrl reset", r, CTRL_RST); check("R2 undef", {31'b0,u}, 0);
        rd9(12, 1, 1, r, u); check("R4 cnten reset", r, 0);
        rd9(14, 1, 1, r, u); check("R5 ien reset", r, 0);
        rd9(13, 1, 1, r, u); check("R7 evtype reset", r, 0);
        rd9(14, 0, 1, r, u); check("R8 uen reset", r, 0);
        rd9(12, 3, 1, r, u); check("R6 ovf reset", r, 0);
    endtask

    task automatic t_ctrl;
        wr9(12, 0, 32'hFFFF_FFFF, 3, u);
        rd9(12, 0, 1, r, u); check("R3 ctrl masked set", r, CTRL_RST | 32'h39);
        wr9(12, 0, 32'h0000_0008, 1, u);
        rd9(12, 0, 1, r, u); check("R3 ctrl masked partial", r, CTRL_RST | 32'h08);
        wr9(12, 0, 32'h0, 1, u);
        rd9(12, 0, 1, r, u); check("R3 ctrl cleared", r, CTRL_RST);
    endtask

    task automatic t_shared;
        wr9(12, 1, 32'h7FFF_FFFF, 1, u);
        rd9(12, 2, 1, r, u); check("R4 set ignores low bits", r, 0);
        wr9(12, 1, 32'hFFFF_FFFF, 1, u);
        rd9(12, 2, 1, r, u); check("R4 set via clr view", r, 32'h8000_0000);
        wr9(12, 2, 32'h7FFF_FFFF, 1, u);
        rd9(12, 1, 1, r, u); check("R4 clr ignores low bits", r, 32'h8000_0000);
        wr9(12, 2, 32'h8000_0000, 1, u);
        rd9(12, 1, 1, r, u); check("R4 clr removes", r, 0);
        wr9(14, 1, 32'h8000_0001, 1, u);
        rd9(14, 2, 1, r, u); check("R5 ien set", r, 32'h8000_0000);
        wr9(14, 2, 32'hFFFF_FFFF, 1, u);
        rd9(14, 1, 1, r, u); check("R5 ien clr", r, 0);
    endtask

    task automatic t_misc;
        wr9(12, 3, 32'hFFFF_FFFF, 1, u);
        rd9(12, 3, 1, r, u); check("R6 ovf w1c", r, 0);
        wr9(13, 1, 32'h1234_ABCD, 1, u);
        rd9(13, 1, 1, r, u); check("R7 evtype low byte", r, 32'hCD);
        wr9(14, 0, 32'hFFFF_FFFE, 1, u);
        rd9(14, 0, 1, r, u); check("R8 uen bit0 only", r, 0);
        wr9(14, 0, 32'h3, 1, u);
        rd9(14, 0, 1, r, u); check("R8 uen set", r, 1);
        wr9(13, 0, 32'hFFFF_FFFF, 1, u); rd9(13, 0, 1, r, u); check("R9 ccnt raz", r, 0);
        wr9(13, 2, 32'hFFFF_FFFF, 1, u); rd9(13, 2, 1, r, u); check("R9 evcnt raz", r, 0);
        wr9(12, 5, 32'hFFFF_FFFF, 1, u); rd9(12, 5, 1, r, u); check("R9 csel raz", r, 0);
        wr9(12, 4, 32'hFFFF_FFFF, 1, u); check("R9 swinc write ok", {31'b0,u}, 0);
        rd9(12, 4, 1, r, u); check("R9 swinc raz", r, 0);
    endtask

    task automatic t_user;
        // user enable is 1 here
        rd9(12, 0, 0, r, u); check("R12 gated read open", r, CTRL_RST); check("R12 no undef", {31'b0,u}, 0);
        rd9(13, 1, 0, r, u); check("R12 evtype user read", r, 32'hCD);
        rd9(14, 0, 0, r, u); check("R11 uen user read", r, 1); check("R11 read no undef", {31'b0,u}, 0);
        wr9(14, 0, 32'h0, 0, u); check("R11 uen user write undef", {31'b0,u}, 1);
        rd9(14, 0, 1, r, u); check("R13 uen kept", r, 1);
        rd9(14, 1, 0, r, u); check("R10 ien user read undef", {31'b0,u}, 1); check("R13 denied data", r, 0);
        wr9(14, 1, 32'h8000_0000, 0, u); check("R10 ien user write undef", {31'b0,u}, 1);
        rd9(14, 1, 1, r, u); check("R13 ien kept", r, 0);
        wr9(14, 0, 32'h0, 1, u);
        rd9(12, 0, 0, r, u); check("R12 gated read closed", {31'b0,u}, 1); check("R13 closed data", r, 0);
        wr9(12, 0, 32'h39, 0, u); check("R12 gated write closed", {31'b0,u}, 1);
        rd9(12, 0, 1, r, u); check("R13 ctrl kept", r, CTRL_RST);
        wr9(13, 1, 32'h55, 0, u); check("R12 evtype closed", {31'b0,u}, 1);
        rd9(13, 1, 1, r, u); check("R13 evtype kept", r, 32'hCD);
        rd9(14, 0, 0, r, u); check("R11 uen read while closed", {31'b0,u}, 0);
    endtask

    task automatic t_decode;
        acc(1'b0, 4'd8, 4'd12, 3'd0, 0, 1, r, u); check("R1 wrong primary", {31'b0,u}, 1);
        rd9(12, 6, 1, r, u); check("R1 sec12 op2 6", {31'b0,u}, 1);
        rd9(13, 3, 1, r, u); check("R1 sec13 op2 3", {31'b0,u}, 1);
        rd9(14, 3, 1, r, u); check("R1 sec14 op2 3", {31'b0,u}, 1);
        rd9(11, 0, 1, r, u); check("R1 sec11", {31'b0,u}, 1); check("R13 undecoded data", r, 0);
        wr9(15, 0, 32'hFFFF_FFFF, 1, u); check("R1 sec15 write", {31'b0,u}, 1);
        rd9(12, 0, 1, r, u); check("R13 ctrl after undecoded", r, CTRL_RST);
    endtask

    task automatic t_idle;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b1; sel_primary = 9; sel_secondary = 12;
        sel_op2 = 0; wr_data = 32'hFFFF_FFFF; priv = 1;
        #1;
        check("R14 idle rdata", rd_data, 0); check("R14 idle undef", {31'b0,undef}, 0);
        @(negedge clk); req_write = 1'b0;
        rd9(12, 0, 1, r, u); check("R14 ctrl unchanged", r, CTRL_RST);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; sel_primary = '0;
        sel_secondary = '0; sel_op2 = '0; wr_data = '0; priv = '0; impl_id = ID_VAL;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_ctrl();
        t_shared();
        t_misc();
        t_user();
        t_decode();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule